// File: doc/BRIEF.md
# Serial Command Decoder with Character Buffer for a Dot-Matrix Display Controller

This block is the host-facing front end of a vacuum fluorescent dot-matrix display controller. A host microcontroller talks to it over a four-wire serial bus that idles high and has an active-low select. Each select window carries one command. The first byte of the window is the opcode, and every byte that follows is an operand for that opcode. The block decodes the opcode and updates one of several items: a 32-entry, 8-bit character buffer written through an auto-incrementing address, a dimming register, a digit-pair count, an operating mode, or a 32-bit cursor mask. Downstream display logic reads these items directly.

While the host clocks bytes in, the block clocks a reply out. For most commands the reply is a key-change status byte repeated in every byte slot. The keyscan read command and the null command return a six-byte packet instead: the status byte followed by the five key-matrix row bytes, repeating if the host keeps clocking. When a keyscan read window closes, the block sends a single-cycle clear strobe to the key scanner.

All four bus pins are oversampled in the system clock domain through a synchronizer. The serial clock therefore has to run well below the system clock; the bench uses 12 system clocks per bit.

Top module: `vfd_cmd_ctrl`

## Requirements
- R1: The bus clock idles high. `simo` is sampled on rising `sclk` edges, MSB first. While `enable_n` is high, `sclk` and `simo` have no effect and `somi_oe` is 0.
- R2: The first byte after `enable_n` falls is always taken as the opcode. Every later byte in the same window is operand data, even when its value matches an opcode.
- R3: Opcode 1000xxxx takes the next byte's bits 4:0 as the write address. Further bytes in that window change nothing.
- R4: Opcode 1001xxxx stores each following byte at the write address and then adds 1 to the address.
- R5: After a store at address 31, the address wraps to 0 and keeps counting on each further byte, but no more stores happen in that window. The next 1001xxxx window stores again, starting at the address reached.
- R6: Opcode 1010xxhh sets `duty[9:8]` = hh, and the next byte gives `duty[7:0]`. Values above 976 are stored as 976.
- R7: Opcode 1011nnnn sets `digit_pairs` to nnnn. 0000 stands for 16 pairs.
- R8: Opcode 1100xmmm sets `mode`: mmm=001 gives 01 (lamp test), 010 gives 10 (low power), 100 gives 11 (blank), and any other mmm gives 00 (normal).
- R9: Opcode 1101xxxx loads its four following bytes into `cursor[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`. Line 1 occupies bits 15:0 and line 2 occupies bits 31:16. Bytes after the fourth are ignored.
- R10: For every opcode other than 1110xxxx and 00h, each byte slot on `somi` is 00h when `key_chg` is 1 and FFh when it is 0. Slot 0 of every window is this status byte.
- R11: For opcodes 1110xxxx and 00h, slot k returns the status byte when k mod 6 = 0. Otherwise it returns {2'b00, row r}, where r = k mod 6, row r sits at `key_rows[6r-1:6r-6]`, and column j maps to bit j-1.
- R12: `rd_clear` pulses high for exactly one cycle after a 1110xxxx window closes, and only while `somi_oe` is 0. Null and all other commands never pulse it.
- R13: After reset, the write address is 0 and `duty`, `digit_pairs`, `mode`, `cursor`, `rd_clear` and `somi_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bus clock, idle high |
| simo | input | 1 | Serial data from host |
| enable_n | input | 1 | Active-low bus select |
| somi | output | 1 | Serial data to host |
| somi_oe | output | 1 | Drive enable for `somi` (tristate control) |
| key_chg | input | 1 | Key scanner reports new key data |
| key_rows | input | 30 | Five 6-bit row snapshots, row 1 in bits 5:0 |
| char_raddr | input | 5 | Character buffer read address |
| char_rdata | output | 8 | Character code at `char_raddr` |
| duty | output | 10 | Dimming value, at most 976 |
| digit_pairs | output | 4 | Digit-pair count (0 means 16) |
| mode | output | 2 | Operating mode code |
| cursor | output | 32 | Cursor mask, line 2 in the upper half |
| rd_clear | output | 1 | One-cycle clear strobe to the key scanner |

## Verification
If the bit counter or the opcode latch slips, the reply on `somi` shifts into the wrong byte slot. That becomes visible at the next sample of the next byte: a row byte arrives where a status byte belongs, or the reverse. If the write address or the wrap-disable flag is wrong, a stored character lands at the wrong location, or the two entries at 0 and 1 get overwritten. These show on `char_raddr`/`char_rdata` as soon as the window ends. A stale operand index leaves a cursor byte in the wrong lane, or a dimming value unclamped. The bench reads those registers back after every window, so any error of this kind shows up within one command.

// File: rtl/vfd_cmd_pkg.sv
`timescale 1ns/1ps
package vfd_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LAMP   = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_BLANK  = 2'd3
  } vfd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_ADDR   = 4'd1,
    OP_CHAR   = 4'd2,
    OP_DUTY   = 4'd3,
    OP_DIGITS = 4'd4,
    OP_MODE   = 4'd5,
    OP_CURSOR = 4'd6,
    OP_KEYRD  = 4'd7,
    OP_NULL   = 4'd8
  } vfd_op_e;

  function automatic vfd_op_e op_decode(input logic [7:0] b);
    vfd_op_e op;
    casez (b)
      8'b0000_0000: op = OP_NULL;
      8'b1000_????: op = OP_ADDR;
      8'b1001_????: op = OP_CHAR;
      8'b1010_????: op = OP_DUTY;
      8'b1011_????: op = OP_DIGITS;
      8'b1100_????: op = OP_MODE;
      8'b1101_????: op = OP_CURSOR;
      8'b1110_????: op = OP_KEYRD;
      default:      op = OP_NONE;
    endcase
    return op;
  endfunction

  function automatic vfd_mode_e mode_decode(input logic [2:0] m);
    vfd_mode_e md;
    case (m)
      3'b001:  md = MODE_LAMP;
      3'b010:  md = MODE_SLEEP;
      3'b100:  md = MODE_BLANK;
      default: md = MODE_NORMAL;
    endcase
    return md;
  endfunction

endpackage

// File: rtl/vfd_sync.sv
`timescale 1ns/1ps
module vfd_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vfd_spi_port.sv
`timescale 1ns/1ps
module vfd_spi_port #(
  parameter int BYTE_W      = 8,
  parameter int SLOTS       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BYTE_W),
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              simo,
  input  logic              enable_n,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [SLOT_W-1:0] tx_slot,
  output logic              sel,
  output logic              sel_start,
  output logic              sel_end,
  output logic              byte_vld,
  output logic              byte_first,
  output logic [BYTE_W-1:0] byte_data,
  output logic              somi
);

  logic ena_s, sclk_s, simo_s;

  vfd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({enable_n, sclk, simo}),
    .q     ({ena_s, sclk_s, simo_s})
  );

  logic              sel_q, sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] shr_q, shr_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              first_q, first_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              vld_q, vld_n;
  logic              bfirst_q, bfirst_n;
  logic [BYTE_W-1:0] data_q, data_n;
  logic              rise, fall, cnt_last;

  assign sel       = ~ena_s;
  assign sel_start = sel & ~sel_q;
  assign sel_end   = ~sel & sel_q;
  assign rise      = sel & sel_q & sclk_s & ~sclk_q;
  assign fall      = sel & sel_q & ~sclk_s & sclk_q;
  assign cnt_last  = (cnt_q == CNT_W'(BYTE_W-1));
  assign tx_slot   = sel_start ? '0 : slot_q;

  always_comb begin
    cnt_n    = cnt_q;
    shr_n    = shr_q;
    slot_n   = slot_q;
    first_n  = first_q;
    tx_n     = tx_q;
    vld_n    = 1'b0;
    bfirst_n = bfirst_q;
    data_n   = data_q;
    if (sel_start) begin
      cnt_n   = '0;
      slot_n  = '0;
      first_n = 1'b1;
      tx_n    = tx_byte;
    end else if (rise) begin
      shr_n = {shr_q[BYTE_W-3:0], simo_s};
      if (cnt_last) begin
        cnt_n    = '0;
        vld_n    = 1'b1;
        data_n   = {shr_q, simo_s};
        bfirst_n = first_q;
        first_n  = 1'b0;
        slot_n   = (slot_q == SLOT_W'(SLOTS-1)) ? '0 : slot_q + 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (fall) begin
      if (cnt_q == '0) tx_n = tx_byte;
      else             tx_n = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      sclk_q   <= 1'b1;
      cnt_q    <= '0;
      shr_q    <= '0;
      slot_q   <= '0;
      first_q  <= 1'b0;
      tx_q     <= '0;
      vld_q    <= 1'b0;
      bfirst_q <= 1'b0;
      data_q   <= '0;
    end else begin
      sel_q    <= sel;
      sclk_q   <= sclk_s;
      cnt_q    <= cnt_n;
      shr_q    <= shr_n;
      slot_q   <= slot_n;
      first_q  <= first_n;
      tx_q     <= tx_n;
      vld_q    <= vld_n;
      bfirst_q <= bfirst_n;
      data_q   <= data_n;
    end
  end

  assign byte_vld   = vld_q;
  assign byte_first = bfirst_q;
  assign byte_data  = data_q;
  assign somi       = tx_q[BYTE_W-1];

  AST_BYTE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(sel)); // R1

endmodule

// File: rtl/vfd_char_buf.sv
`timescale 1ns/1ps
module vfd_char_buf #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/vfd_cmd_regs.sv
`timescale 1ns/1ps
module vfd_cmd_regs
  import vfd_cmd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int DUTY_W    = 10,
  parameter int DUTY_MAX  = 976,
  parameter int DIGIT_W   = 4,
  parameter int CUR_BYTES = 4,
  localparam int CUR_W    = CUR_BYTES * DATA_W,
  localparam int DIDX_W   = $clog2(CUR_BYTES + 1),
  localparam int HI_W     = DUTY_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_start,
  input  logic               sel_end,
  input  logic               byte_vld,
  input  logic               byte_first,
  input  logic [DATA_W-1:0]  byte_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [DUTY_W-1:0]  duty,
  output logic [DIGIT_W-1:0] digits,
  output vfd_mode_e          mode,
  output logic [CUR_W-1:0]   cursor,
  output logic               pkt_cmd,
  output logic               rd_clear
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  vfd_op_e            op_q, op_n;
  logic [HI_W-1:0]    hi_q, hi_n;
  logic [DIDX_W-1:0]  didx_q, didx_n;
  logic               wr_dis_q, wr_dis_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [DUTY_W-1:0]  duty_q, duty_n, duty_raw;
  logic [DIGIT_W-1:0] digits_q, digits_n;
  vfd_mode_e          mode_q, mode_n;
  logic [CUR_W-1:0]   cursor_q, cursor_n;
  logic               clr_q, clr_n;
  logic               data_byte;
  vfd_op_e            op_new;

  assign data_byte = byte_vld & ~byte_first;
  assign op_new    = op_decode(byte_data);
  assign duty_raw  = {hi_q, byte_data};
  assign wr_en     = data_byte & (op_q == OP_CHAR) & ~wr_dis_q;

  always_comb begin
    op_n     = op_q;
    hi_n     = hi_q;
    didx_n   = didx_q;
    wr_dis_n = wr_dis_q;
    addr_n   = addr_q;
    duty_n   = duty_q;
    digits_n = digits_q;
    mode_n   = mode_q;
    cursor_n = cursor_q;
    clr_n    = sel_end & (op_q == OP_KEYRD);
    if (sel_start) begin
      op_n     = OP_NONE;
      didx_n   = '0;
      wr_dis_n = 1'b0;
    end else if (byte_vld && byte_first) begin
      op_n   = op_new;
      hi_n   = byte_data[HI_W-1:0];
      didx_n = '0;
      if (op_new == OP_DIGITS) digits_n = byte_data[DIGIT_W-1:0];
      if (op_new == OP_MODE)   mode_n   = mode_decode(byte_data[2:0]);
    end else if (data_byte) begin
      if (didx_q != DIDX_W'(CUR_BYTES)) didx_n = didx_q + 1'b1;
      case (op_q)
        OP_ADDR: begin
          if (didx_q == '0) addr_n = byte_data[ADDR_W-1:0];
        end
        OP_CHAR: begin
          addr_n = addr_q + 1'b1;
          if (!wr_dis_q && addr_q == ADDR_TOP) wr_dis_n = 1'b1;
        end
        OP_DUTY: begin
          if (didx_q == '0)
            duty_n = (duty_raw > DUTY_W'(DUTY_MAX)) ? DUTY_W'(DUTY_MAX) : duty_raw;
        end
        OP_CURSOR: begin
          for (int i = 0; i < CUR_BYTES; i++)
            if (didx_q == DIDX_W'(i)) cursor_n[i*DATA_W +: DATA_W] = byte_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      hi_q     <= '0;
      didx_q   <= '0;
      wr_dis_q <= 1'b0;
      addr_q   <= '0;
      duty_q   <= '0;
      digits_q <= '0;
      mode_q   <= MODE_NORMAL;
      cursor_q <= '0;
      clr_q    <= 1'b0;
    end else begin
      op_q     <= op_n;
      hi_q     <= hi_n;
      didx_q   <= didx_n;
      wr_dis_q <= wr_dis_n;
      addr_q   <= addr_n;
      duty_q   <= duty_n;
      digits_q <= digits_n;
      mode_q   <= mode_n;
      cursor_q <= cursor_n;
      clr_q    <= clr_n;
    end
  end

  assign wr_addr  = addr_q;
  assign wr_data  = byte_data;
  assign duty     = duty_q;
  assign digits   = digits_q;
  assign mode     = mode_q;
  assign cursor   = cursor_q;
  assign pkt_cmd  = (op_q == OP_KEYRD) | (op_q == OP_NULL);
  assign rd_clear = clr_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == $past(wr_addr) + ADDR_W'(1))); // R4

  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= DUTY_W'(DUTY_MAX)); // R6

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> !rd_clear); // R12

endmodule

// File: rtl/vfd_cmd_ctrl.sv
`timescale 1ns/1ps
module vfd_cmd_ctrl
  import vfd_cmd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BYTE_W      = 8,
  parameter int DUTY_W      = 10,
  parameter int DUTY_MAX    = 976,
  parameter int DIGIT_W     = 4,
  parameter int ROWS        = 5,
  parameter int COLS        = 6,
  parameter int CUR_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SLOTS      = ROWS + 1,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int CUR_W      = CUR_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 simo,
  input  logic                 enable_n,
  output logic                 somi,
  output logic                 somi_oe,
  input  logic                 key_chg,
  input  logic [ROWS*COLS-1:0] key_rows,
  input  logic [ADDR_W-1:0]    char_raddr,
  output logic [BYTE_W-1:0]    char_rdata,
  output logic [DUTY_W-1:0]    duty,
  output logic [DIGIT_W-1:0]   digit_pairs,
  output logic [1:0]           mode,
  output logic [CUR_W-1:0]     cursor,
  output logic                 rd_clear
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [BYTE_W-1:0] tx_byte, status_byte, byte_data, wr_data;
  logic [SLOT_W-1:0] tx_slot;
  logic              sel, sel_start, sel_end, byte_vld, byte_first;
  logic              wr_en, pkt_cmd;
  logic [ADDR_W-1:0] wr_addr;
  vfd_mode_e         mode_e;
  logic [BYTE_W-1:0] pkt [SLOTS];

  assign status_byte = key_chg ? '0 : '1;
  assign pkt[0]      = status_byte;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign pkt[r+1] = BYTE_W'(key_rows[r*COLS +: COLS]);
  end

  assign tx_byte = pkt_cmd ? pkt[tx_slot] : status_byte;

  vfd_spi_port #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sclk       (sclk),
    .simo       (simo),
    .enable_n   (enable_n),
    .tx_byte    (tx_byte),
    .tx_slot    (tx_slot),
    .sel        (sel),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .byte_vld   (byte_vld),
    .byte_first (byte_first),
    .byte_data  (byte_data),
    .somi       (somi)
  );

  vfd_cmd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX),
    .DIGIT_W(DIGIT_W), .CUR_BYTES(CUR_BYTES)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .byte_vld   (byte_vld),
    .byte_first (byte_first),
    .byte_data  (byte_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .duty       (duty),
    .digits     (digit_pairs),
    .mode       (mode_e),
    .cursor     (cursor),
    .pkt_cmd    (pkt_cmd),
    .rd_clear   (rd_clear)
  );

  vfd_char_buf #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (char_raddr),
    .rd_data (char_rdata)
  );

  assign mode    = mode_e;
  assign somi_oe = sel;

  AST_CLR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_clear |-> !somi_oe); // R12

endmodule

// File: tb/vfd_cmd_ctrl_test.sv
`timescale 1ns/1ps
module vfd_cmd_ctrl_test;

  logic        clk, rst_n, sclk, simo, enable_n, key_chg;
  logic [29:0] key_rows;
  logic [4:0]  char_raddr;
  logic        somi, somi_oe, rd_clear;
  logic [7:0]  char_rdata;
  logic [9:0]  duty;
  logic [3:0]  digit_pairs;
  logic [1:0]  mode;
  logic [31:0] cursor;

  vfd_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .simo(simo), .enable_n(enable_n),
    .somi(somi), .somi_oe(somi_oe), .key_chg(key_chg), .key_rows(key_rows),
    .char_raddr(char_raddr), .char_rdata(char_rdata), .duty(duty),
    .digit_pairs(digit_pairs), .mode(mode), .cursor(cursor), .rd_clear(rd_clear)
  );

  localparam int HALF = 6;
  localparam int NV   = 16;
  // {opcode, operand, field (0 duty,1 digits,2 mode), expected}
  localparam logic [31:0] VEC [NV] = '{
    32'hA1230123, 32'hA3FF03D0, 32'hA3D003D0, 32'hA3D103D0,
    32'hA3CF03CF, 32'hA0000000, 32'hB5001005, 32'hBF00100F,
    32'hB0001000, 32'hC1002001, 32'hC2002002, 32'hC4002003,
    32'hC3002000, 32'hC9002001, 32'hCA002002, 32'hC7002000
  };

  int n_chk, n_err, clr_cnt;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && rd_clear === 1'b1) clr_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    enable_n = 1'b0;
    wclk(HALF);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        sclk = 1'b0;
        simo = tx_buf[b][i];
        wclk(HALF);
        rx_buf[b][i] = somi;
        sclk = 1'b1;
        wclk(HALF);
      end
    end
    wclk(HALF);
    enable_n = 1'b1;
    wclk(8);
  endtask

  function automatic logic [7:0] exp_pkt(input int k, input logic chg);
    int s;
    s = k % 6;
    if (s == 0) return chg ? 8'h00 : 8'hFF;
    return {2'b00, key_rows[(s-1)*6 +: 6]};
  endfunction

  task automatic rd_char(input logic [4:0] a, input logic [7:0] exp, input string req);
    char_raddr = a;
    wclk(1);
    chk(req, 32'(char_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; clr_cnt = 0;
    enable_n = 1'b1; sclk = 1'b1; simo = 1'b0; key_chg = 1'b0;
    key_rows = '0; char_raddr = '0; rst_n = 1'b0;
    wclk(5);
    // R13 reset state
    chk("R13 duty", 32'(duty), 0);
    chk("R13 digits", 32'(digit_pairs), 0);
    chk("R13 mode", 32'(mode), 0);
    chk("R13 cursor", cursor, 0);
    chk("R13 somi_oe", 32'(somi_oe), 0);
    chk("R13 rd_clear", 32'(rd_clear), 0);
    rst_n = 1'b1;
    wclk(6);

    // R13/R4: write address starts at 0; R10 status FF without change
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h5A; tx_buf[2] = 8'h5B; tx_buf[3] = 8'h5C;
    xfer(4);
    rd_char(5'd0, 8'h5A, "R13 addr0");
    rd_char(5'd1, 8'h5B, "R4 addr1");
    rd_char(5'd2, 8'h5C, "R4 addr2");
    for (int b = 0; b < 4; b++) chk("R10 status FF", 32'(rx_buf[b]), 32'hFF);

    // Vector table: duty R6, digits R7, mode R8
    for (int v = 0; v < NV; v++) begin
      tx_buf[0] = VEC[v][31:24];
      tx_buf[1] = VEC[v][23:16];
      xfer((VEC[v][15:12] == 4'd0) ? 2 : 1);
      case (VEC[v][15:12])
        4'd0:    chk("R6 duty", 32'(duty), 32'(VEC[v][11:0]));
        4'd1:    chk("R7 digits", 32'(digit_pairs), 32'(VEC[v][11:0]));
        default: chk("R8 mode", 32'(mode), 32'(VEC[v][11:0]));
      endcase
    end

    // R3/R4: address set then successive writes
    tx_buf[0] = 8'h80; tx_buf[1] = 8'hE5; xfer(2);
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h41; tx_buf[2] = 8'h42; tx_buf[3] = 8'h43; xfer(4);
    rd_char(5'd5, 8'h41, "R3 addr from low bits");
    rd_char(5'd6, 8'h42, "R4 incr");
    rd_char(5'd7, 8'h43, "R4 incr");
    tx_buf[0] = 8'h80; tx_buf[1] = 8'h03; tx_buf[2] = 8'h17; xfer(3);
    tx_buf[0] = 8'h90; tx_buf[1] = 8'hAA; xfer(2);
    rd_char(5'd3, 8'hAA, "R3 extra byte ignored");
    rd_char(5'd7, 8'h43, "R3 no stray write");

    // R5: wrap at the top with writes suppressed
    tx_buf[0] = 8'h80; tx_buf[1] = 8'h1E; xfer(2);
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22;
    tx_buf[3] = 8'h33; tx_buf[4] = 8'h44; xfer(5);
    rd_char(5'd30, 8'h11, "R5 addr30");
    rd_char(5'd31, 8'h22, "R5 addr31");
    rd_char(5'd0, 8'h5A, "R5 addr0 kept");
    rd_char(5'd1, 8'h5B, "R5 addr1 kept");
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h55; xfer(2);
    rd_char(5'd2, 8'h55, "R5 count continued");

    // R9 cursor lanes
    tx_buf[0] = 8'hD0; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02;
    tx_buf[3] = 8'h03; tx_buf[4] = 8'h04; tx_buf[5] = 8'h05; xfer(6);
    chk("R9 cursor", cursor, 32'h04030201);

    // R1: bus activity with select high is ignored
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; simo = 1'(8'hB3 >> i); wclk(3);
      if (i == 4) chk("R1 somi_oe idle", 32'(somi_oe), 0);
      sclk = 1'b1; wclk(3);
    end
    wclk(4);
    chk("R1 digits unchanged", 32'(digit_pairs), 0);

    // R2: opcode then operand that looks like an opcode
    tx_buf[0] = 8'hB7; tx_buf[1] = 8'hB2; xfer(2);
    chk("R2 second byte is data", 32'(digit_pairs), 7);

    // R10 status 00 on change; R12 no clear from other command
    key_chg = 1'b1;
    tx_buf[0] = 8'hC0; tx_buf[1] = 8'hAB; tx_buf[2] = 8'hCD; xfer(3);
    for (int b = 0; b < 3; b++) chk("R10 status 00", 32'(rx_buf[b]), 0);
    chk("R12 no clear yet", clr_cnt, 0);

    // R11 packet with null command, wrapping; R12 no clear
    key_rows = {6'h0A, 6'h10, 6'h3F, 6'h22, 6'h01};
    tx_buf[0] = 8'h00;
    for (int b = 1; b < 8; b++) tx_buf[b] = 8'hFF;
    xfer(8);
    for (int b = 0; b < 8; b++) chk("R11 null packet", 32'(rx_buf[b]), 32'(exp_pkt(b, 1'b1)));
    chk("R12 null no clear", clr_cnt, 0);

    // R11 keyscan read, R12 one clear
    tx_buf[0] = 8'hE5;
    xfer(6);
    for (int b = 0; b < 6; b++) chk("R11 read packet", 32'(rx_buf[b]), 32'(exp_pkt(b, 1'b1)));
    chk("R12 one clear", clr_cnt, 1);

    key_chg = 1'b0;
    tx_buf[0] = 8'hE0; tx_buf[1] = 8'h00; xfer(2);
    chk("R11 status FF in packet", 32'(rx_buf[0]), 32'hFF);
    chk("R11 row1", 32'(rx_buf[1]), 32'h01);
    chk("R12 second clear", clr_cnt, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule